// File: doc/BRIEF.md
# Majority-Clocked Three-Register Keystream Generator

This block produces a keystream one bit per clock from three linear feedback shift registers of unequal length. Their stepping is irregular: a vote over one clocking bit from each register decides which of them advance in a given cycle. A 64-bit key and a 22-bit frame count arrive serially, one bit per accepted handshake. During this load every register advances on each accepted bit, and the incoming bit is folded into every feedback path. A fixed run of voted steps then mixes the state, and those output bits are thrown away.

After mixing, the generator gathers keystream bits into a word of `WORD_W` bits. When a whole word is ready, the block accepts one data word, XORs it with the gathered keystream, and presents the result through a registered write strobe. The downstream side can hold the block off with a full flag. While the block is held off, the generator pauses, so no keystream bit is lost. Applying reset and loading a new key restarts the sequence.

Top module: `ks_maj3_gen`

## Requirements
- R1: After reset, `key_iv_rdy` is 1, `data_in_rdy` is 0, `dout_wr` is 0, and all three registers hold zero.
- R2: Registers are 19, 22 and 23 bits long. Each shifts toward its MSB, and the new bit enters at bit 0. The feedback is the XOR of bits {13,16,17,18}, {20,21} and {7,20,21,22} respectively. Every accepted load bit (`key_iv_wr` while `key_iv_rdy`) steps all three registers, and that bit is XORed into each feedback. The bit order is key bit 0 through 63, then frame bit 0 through 21. A cycle without a write steps nothing.
- R3: `key_iv_rdy` falls right after the 86th accepted load bit. Later `key_iv_wr` activity has no effect until reset. `key_iv_rdy` and `data_in_rdy` are never both 1.
- R4: After loading, 100 voted steps run with their output discarded. `data_in_rdy` first rises exactly 100 + `WORD_W` clock edges after the edge that accepted the last load bit.
- R5: The clocking bits are bit 8, bit 10 and bit 10 of the three registers. A register steps only when its clocking bit equals the majority of the three, so in every voted step at least two registers move.
- R6: A keystream bit is the XOR of the three register MSBs taken after the step that produced it. Word bit j uses the j-th keystream bit gathered for that word.
- R7: One edge after a data word is accepted (`data_in_wr` while `data_in_rdy`), `dout_wr` is 1 for one cycle and `data_out` equals `data_in` XOR the keystream word.
- R8: `data_in_rdy` is 1 only after mixing, with a full word gathered and `dout_full` at 0. While a word is waiting, the generator does not step, so no keystream bit is skipped.
- R9: The cycle that accepts a word also generates the first bit of the next word. Holding `data_in_wr` high therefore gives one word every `WORD_W` cycles.
- R10: An all-zero key and frame count leave the state at zero, so `data_out` equals `data_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| key_iv_bit | input | 1 | Serial key / frame-count bit |
| key_iv_wr | input | 1 | Load bit is valid |
| key_iv_rdy | output | 1 | Block accepts load bits |
| data_in | input | WORD_W | Data word to combine with the keystream |
| data_in_wr | input | 1 | Data word is valid |
| data_in_rdy | output | 1 | Keystream word ready and output not full |
| data_out | output | WORD_W | Data XOR keystream |
| dout_wr | output | 1 | `data_out` is valid for this cycle |
| dout_full | input | 1 | Downstream cannot take a word |

## Verification
Two events can land in the same cycle: a data word is consumed, and the first keystream bit of the next word is generated. The bench holds `data_in_wr` high across several words to force this overlap on every word. It then checks that each result matches a bit-level software model of the registers and that accepts fall exactly `WORD_W` cycles apart. Any lost or doubled bit at the boundary would shift every later word. A second overlap pairs a held-off word with a raised full flag. Here the bench confirms that the pause consumes no keystream, because the word sent after release still matches the model.

// File: rtl/ks_maj3_pkg.sv
`timescale 1ns/1ps
package ks_maj3_pkg;

   typedef enum logic [1:0] {
      PH_LOAD = 2'd0,
      PH_MIX  = 2'd1,
      PH_RUN  = 2'd2
   } ks_phase_t;

   localparam int unsigned NUM_REGS = 3;

   function automatic logic maj3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

endpackage

// File: rtl/ks_lfsr_stage.sv
`timescale 1ns/1ps
module ks_lfsr_stage #(
   parameter int          LEN    = 19,
   parameter logic [31:0] TAPS   = 32'h0007_2000,
   parameter int          CK_POS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   input  logic inject,
   output logic clk_bit,
   output logic nxt_msb
);

   if (LEN < 2 || LEN > 32 || CK_POS < 0 || CK_POS >= LEN) begin : g_bad_shape
      $error("ks_lfsr_stage: length or clocking position out of range");
   end

   logic [LEN-1:0] sr;
   logic [LEN-1:0] sr_nxt;
   logic           fb;

   always_comb begin
      fb      = (^(sr & TAPS[LEN-1:0])) ^ inject;
      sr_nxt  = {sr[LEN-2:0], fb};
      clk_bit = sr[CK_POS];
      nxt_msb = step ? sr_nxt[LEN-1] : sr[LEN-1];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    sr <= '0;
      else if (step) sr <= sr_nxt;
   end

endmodule

// File: rtl/ks_majority_vote.sv
`timescale 1ns/1ps
module ks_majority_vote
   import ks_maj3_pkg::*;
(
   input  logic [NUM_REGS-1:0] ck_bits,
   output logic [NUM_REGS-1:0] step_en
);

   logic vote;

   assign vote = maj3(ck_bits[0], ck_bits[1], ck_bits[2]);

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_agree
      assign step_en[g] = ~(ck_bits[g] ^ vote);
   end

endmodule

// File: rtl/ks_seq_ctrl.sv
`timescale 1ns/1ps
module ks_seq_ctrl
   import ks_maj3_pkg::*;
#(
   parameter int LOAD_BITS  = 86,
   parameter int MIX_CYCLES = 100,
   parameter int WORD_W     = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic key_iv_wr,
   input  logic data_in_wr,
   input  logic dout_full,
   output logic key_iv_rdy,
   output logic data_in_rdy,
   output logic load_step,
   output logic maj_en,
   output logic run_step,
   output logic take
);

   if (LOAD_BITS < 1 || MIX_CYCLES < 1 || WORD_W < 1) begin : g_bad_counts
      $error("ks_seq_ctrl: load, mix and word counts must be positive");
   end

   localparam int LCW = $clog2(LOAD_BITS + 1);
   localparam int MCW = $clog2(MIX_CYCLES + 1);
   localparam int BCW = $clog2(WORD_W + 1);
   localparam logic [LCW-1:0] LD_LAST  = LCW'(LOAD_BITS - 1);
   localparam logic [MCW-1:0] MX_LAST  = MCW'(MIX_CYCLES - 1);
   localparam logic [BCW-1:0] BIT_FULL = BCW'(WORD_W);

   ks_phase_t      ph;
   logic [LCW-1:0] ld_cnt;
   logic [MCW-1:0] mx_cnt;
   logic [BCW-1:0] bit_cnt;
   logic           word_full;

   always_comb begin
      word_full   = (bit_cnt == BIT_FULL);
      key_iv_rdy  = (ph == PH_LOAD);
      load_step   = key_iv_rdy & key_iv_wr;
      data_in_rdy = (ph == PH_RUN) & word_full & ~dout_full;
      take        = data_in_rdy & data_in_wr;
      run_step    = (ph == PH_RUN) & (~word_full | take);
      maj_en      = (ph == PH_MIX) | run_step;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph      <= PH_LOAD;
         ld_cnt  <= '0;
         mx_cnt  <= '0;
         bit_cnt <= '0;
      end else begin
         case (ph)
            PH_LOAD: begin
               if (load_step) begin
                  if (ld_cnt == LD_LAST) begin
                     ld_cnt <= '0;
                     ph     <= PH_MIX;
                  end else begin
                     ld_cnt <= ld_cnt + 1'b1;
                  end
               end
            end
            PH_MIX: begin
               if (mx_cnt == MX_LAST) begin
                  mx_cnt <= '0;
                  ph     <= PH_RUN;
               end else begin
                  mx_cnt <= mx_cnt + 1'b1;
               end
            end
            PH_RUN: begin
               if (run_step) bit_cnt <= take ? BCW'(1) : bit_cnt + 1'b1;
            end
            default: ph <= PH_LOAD;
         endcase
      end
   end

endmodule

// File: rtl/ks_word_xor.sv
`timescale 1ns/1ps
module ks_word_xor #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_step,
   input  logic              take,
   input  logic              ks_bit,
   input  logic [WORD_W-1:0] data_in,
   output logic [WORD_W-1:0] data_out,
   output logic              dout_wr
);

   logic [WORD_W-1:0] ks_buf;

   if (WORD_W == 1) begin : g_single
      always_ff @(posedge clk) begin
         if (!rst_n)        ks_buf <= '0;
         else if (run_step) ks_buf <= ks_bit;
      end
   end else begin : g_shift
      always_ff @(posedge clk) begin
         if (!rst_n)        ks_buf <= '0;
         else if (run_step) begin
            if (take) ks_buf <= {ks_bit, {(WORD_W-1){1'b0}}};
            else      ks_buf <= {ks_bit, ks_buf[WORD_W-1:1]};
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_out <= '0;
         dout_wr  <= 1'b0;
      end else begin
         dout_wr <= take;
         if (take) data_out <= data_in ^ ks_buf;
      end
   end

endmodule

// File: rtl/ks_maj3_gen.sv
`timescale 1ns/1ps
module ks_maj3_gen
   import ks_maj3_pkg::*;
#(
   parameter int          KEY_BITS   = 64,
   parameter int          IV_BITS    = 22,
   parameter int          MIX_CYCLES = 100,
   parameter int          WORD_W     = 8,
   parameter int          LEN_A      = 19,
   parameter int          LEN_B      = 22,
   parameter int          LEN_C      = 23,
   parameter logic [31:0] TAPS_A     = 32'h0007_2000,
   parameter logic [31:0] TAPS_B     = 32'h0030_0000,
   parameter logic [31:0] TAPS_C     = 32'h0070_0080,
   parameter int          CK_A       = 8,
   parameter int          CK_B       = 10,
   parameter int          CK_C       = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_iv_bit,
   input  logic              key_iv_wr,
   output logic              key_iv_rdy,
   input  logic [WORD_W-1:0] data_in,
   input  logic              data_in_wr,
   output logic              data_in_rdy,
   output logic [WORD_W-1:0] data_out,
   output logic              dout_wr,
   input  logic              dout_full
);

   localparam int LOAD_BITS = KEY_BITS + IV_BITS;

   if (KEY_BITS < 1 || IV_BITS < 0) begin : g_bad_load
      $error("ks_maj3_gen: key length must be positive");
   end

   logic                load_step;
   logic                maj_en;
   logic                run_step;
   logic                take;
   logic                inject;
   logic                ks_bit;
   logic [NUM_REGS-1:0] ck_bits;
   logic [NUM_REGS-1:0] vote;
   logic [NUM_REGS-1:0] step_vec;
   logic [NUM_REGS-1:0] nmsb;

   ks_seq_ctrl #(
      .LOAD_BITS (LOAD_BITS),
      .MIX_CYCLES(MIX_CYCLES),
      .WORD_W    (WORD_W)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .key_iv_wr  (key_iv_wr),
      .data_in_wr (data_in_wr),
      .dout_full  (dout_full),
      .key_iv_rdy (key_iv_rdy),
      .data_in_rdy(data_in_rdy),
      .load_step  (load_step),
      .maj_en     (maj_en),
      .run_step   (run_step),
      .take       (take)
   );

   ks_majority_vote u_vote (
      .ck_bits(ck_bits),
      .step_en(vote)
   );

   assign inject   = load_step & key_iv_bit;
   assign step_vec = {NUM_REGS{load_step}} | ({NUM_REGS{maj_en}} & vote);
   assign ks_bit   = ^nmsb;

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      localparam int          L = (g == 0) ? LEN_A  : (g == 1) ? LEN_B  : LEN_C;
      localparam logic [31:0] T = (g == 0) ? TAPS_A : (g == 1) ? TAPS_B : TAPS_C;
      localparam int          C = (g == 0) ? CK_A   : (g == 1) ? CK_B   : CK_C;
      ks_lfsr_stage #(
         .LEN   (L),
         .TAPS  (T),
         .CK_POS(C)
      ) u_stage (
         .clk    (clk),
         .rst_n  (rst_n),
         .step   (step_vec[g]),
         .inject (inject),
         .clk_bit(ck_bits[g]),
         .nxt_msb(nmsb[g])
      );
   end

   ks_word_xor #(
      .WORD_W(WORD_W)
   ) u_xor (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_step(run_step),
      .take    (take),
      .ks_bit  (ks_bit),
      .data_in (data_in),
      .data_out(data_out),
      .dout_wr (dout_wr)
   );

endmodule

// File: rtl/ks_maj3_checker.sv
`timescale 1ns/1ps
module ks_maj3_checker #(
   parameter int WORD_W = 8
) (
   input logic       clk,
   input logic       rst_n,
   input logic       key_iv_wr,
   input logic       key_iv_rdy,
   input logic       data_in_wr,
   input logic       data_in_rdy,
   input logic       dout_wr,
   input logic       dout_full,
   input logic [2:0] step_vec
);

   // R3: load and data phases never overlap
   assert_rdy_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(key_iv_rdy && data_in_rdy));

   // R3: load phase closes only on an accepted write
   assert_load_close_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(key_iv_rdy) |-> $past(key_iv_wr));

   // R5: a voted step always moves two or three registers
   assert_step_quorum_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (|step_vec) |-> ($countones(step_vec) >= 2));

   // R7: an output strobe always follows an accepted word
   assert_out_follows_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dout_wr |-> $past(data_in_wr && data_in_rdy));

   // R8: full flag blocks acceptance
   assert_full_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      dout_full |-> !data_in_rdy);

   // R8: a waiting word stays ready unless the output fills
   assert_ready_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (data_in_rdy && !data_in_wr) |=> (data_in_rdy || dout_full));

   // R9: acceptance empties the gathered word
   assert_take_drains_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (data_in_wr && data_in_rdy && (WORD_W > 1)) |=> !data_in_rdy);

endmodule

bind ks_maj3_gen ks_maj3_checker #(
   .WORD_W(WORD_W)
) u_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .key_iv_wr  (key_iv_wr),
   .key_iv_rdy (key_iv_rdy),
   .data_in_wr (data_in_wr),
   .data_in_rdy(data_in_rdy),
   .dout_wr    (dout_wr),
   .dout_full  (dout_full),
   .step_vec   (step_vec)
);

// File: tb/ks_maj3_gen_tb_top.sv
`timescale 1ns/1ps
module ks_maj3_gen_tb_top;

   localparam int W     = 8;
   localparam int MIX   = 100;
   localparam int KS_N  = 512;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         key_iv_bit = 1'b0;
   logic         key_iv_wr = 1'b0;
   logic         key_iv_rdy;
   logic [W-1:0] data_in = '0;
   logic         data_in_wr = 1'b0;
   logic         data_in_rdy;
   logic [W-1:0] data_out;
   logic         dout_wr;
   logic         dout_full = 1'b0;

   int n_chk  = 0;
   int n_fail = 0;
   int widx   = 0;
   int cyc    = 0;
   bit done   = 1'b0;

   logic [18:0] ra;
   logic [21:0] rb;
   logic [22:0] rc;
   logic        ks_ref [KS_N];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   ks_maj3_gen #(.WORD_W(W), .MIX_CYCLES(MIX)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .key_iv_bit (key_iv_bit),
      .key_iv_wr  (key_iv_wr),
      .key_iv_rdy (key_iv_rdy),
      .data_in    (data_in),
      .data_in_wr (data_in_wr),
      .data_in_rdy(data_in_rdy),
      .data_out   (data_out),
      .dout_wr    (dout_wr),
      .dout_full  (dout_full)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
      end
   endtask

   // software model of the three voted registers
   task automatic ref_clock(input bit all, input bit inj, output bit o);
      bit m;
      m = (ra[8] & rb[10]) | (ra[8] & rc[10]) | (rb[10] & rc[10]);
      if (all || ra[8] == m) ra = {ra[17:0], ra[18] ^ ra[17] ^ ra[16] ^ ra[13] ^ inj};
      if (all || rb[10] == m) rb = {rb[20:0], rb[21] ^ rb[20] ^ inj};
      if (all || rc[10] == m) rc = {rc[21:0], rc[22] ^ rc[21] ^ rc[20] ^ rc[7] ^ inj};
      o = ra[18] ^ rb[21] ^ rc[22];
   endtask

   task automatic ref_build(input logic [63:0] k, input logic [21:0] f);
      bit o;
      ra = '0; rb = '0; rc = '0;
      for (int i = 0; i < 64; i++) ref_clock(1'b1, k[i], o);
      for (int i = 0; i < 22; i++) ref_clock(1'b1, f[i], o);
      for (int i = 0; i < MIX; i++) ref_clock(1'b0, 1'b0, o);
      for (int i = 0; i < KS_N; i++) begin
         ref_clock(1'b0, 1'b0, o);
         ks_ref[i] = o;
      end
      widx = 0;
   endtask

   function automatic logic [W-1:0] ks_word(input int idx);
      logic [W-1:0] w;
      for (int j = 0; j < W; j++) w[j] = ks_ref[idx*W + j];
      return w;
   endfunction

   task automatic do_reset();
      rst_n = 1'b0; key_iv_wr = 1'b0; data_in_wr = 1'b0; dout_full = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // R1
   task automatic t_reset_state();
      do_reset();
      chk("R1 key_iv_rdy", 32'(key_iv_rdy), 32'd1);
      chk("R1 data_in_rdy", 32'(data_in_rdy), 32'd0);
      chk("R1 dout_wr", 32'(dout_wr), 32'd0);
   endtask

   // R2, R3, R4: serial load with optional idle gaps, junk writes while mixing
   task automatic t_load(input logic [63:0] k, input logic [21:0] f, input bit gaps);
      int cycles;
      ref_build(k, f);
      for (int i = 0; i < 86; i++) begin
         if (gaps && (i % 5 == 2)) begin
            key_iv_wr  = 1'b0;
            key_iv_bit = 1'b1;
            @(negedge clk);
         end
         key_iv_bit = (i < 64) ? k[i] : f[i-64];
         key_iv_wr  = 1'b1;
         @(negedge clk);
         key_iv_wr  = 1'b0;
      end
      chk("R3 key_iv_rdy after last bit", 32'(key_iv_rdy), 32'd0);
      key_iv_wr  = 1'b1;
      key_iv_bit = 1'b1;
      cycles = 0;
      while (!data_in_rdy && cycles < 2000) begin
         @(negedge clk);
         cycles++;
      end
      key_iv_wr = 1'b0;
      chk("R4 load-to-ready latency", 32'(cycles), 32'(MIX + W));
   endtask

   // R6, R7: one word with full check of the result
   task automatic send_word(input logic [W-1:0] d, input string req);
      int guard = 0;
      while (!data_in_rdy && guard < 2000) begin
         @(negedge clk);
         guard++;
      end
      data_in    = d;
      data_in_wr = 1'b1;
      @(negedge clk);
      data_in_wr = 1'b0;
      chk({req, " dout_wr"}, 32'(dout_wr), 32'd1);
      chk({req, " data_out"}, 32'(data_out), 32'(d ^ ks_word(widx)));
      widx++;
   endtask

   task automatic t_words();
      send_word(8'h00, "R6");
      send_word(8'hFF, "R7");
      repeat (4) @(negedge clk);
      chk("R7 strobe single cycle", 32'(dout_wr), 32'd0);
      send_word(8'hA5, "R5");
      send_word(8'h5A, "R7");
   endtask

   // R8: held-off word loses no keystream
   task automatic t_backpressure();
      int guard = 0;
      while (!data_in_rdy && guard < 2000) begin
         @(negedge clk);
         guard++;
      end
      dout_full  = 1'b1;
      data_in_wr = 1'b1;
      data_in    = 8'h77;
      #1;
      chk("R8 rdy low under full", 32'(data_in_rdy), 32'd0);
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         chk("R8 no output under full", 32'(dout_wr), 32'd0);
      end
      dout_full  = 1'b0;
      data_in_wr = 1'b0;
      send_word(8'h3C, "R8 after release");
   endtask

   // R9: continuous writes, accept and next-bit generation share a cycle
   task automatic t_stream(input int n);
      int last = -1;
      int guard;
      data_in_wr = 1'b1;
      for (int k = 0; k < n; k++) begin
         guard = 0;
         while (!data_in_rdy && guard < 2000) begin
            @(negedge clk);
            guard++;
         end
         data_in = W'(8'h11 * (k + 1));
         if (last >= 0) chk("R9 accept spacing", 32'(cyc - last), 32'(W));
         last = cyc;
         @(negedge clk);
         chk("R9 dout_wr", 32'(dout_wr), 32'd1);
         chk("R9 data_out", 32'(data_out), 32'(W'(8'h11 * (k + 1)) ^ ks_word(widx)));
         widx++;
      end
      data_in_wr = 1'b0;
   endtask

   // R10 and R1: zero key keeps zero state
   task automatic t_zero();
      do_reset();
      t_load(64'd0, 22'd0, 1'b0);
      for (int k = 0; k < 3; k++) begin
         send_word(W'(8'hC3 + k), "R10");
         chk("R10 pass-through", 32'(data_out), 32'(W'(8'hC3 + k)));
      end
   endtask

   initial begin
      t_reset_state();
      t_load(64'h1223_4567_89AB_CDEF, 22'h134, 1'b1);
      t_words();
      t_backpressure();
      t_stream(6);
      do_reset();
      chk("R1 ready after re-reset", 32'(key_iv_rdy), 32'd1);
      t_load(64'hF0E1_D2C3_B4A5_9687, 22'h3F_FFFF, 1'b0);
      t_stream(5);
      t_words();
      t_zero();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule